// File: doc/BRIEF.md
# Cartridge PRG Banking and Mirroring Controller

This block sits between the console CPU bus and a cartridge's program ROM and work RAM. It watches CPU writes to the upper half of the address space and keeps a small set of control registers. From them it drives the upper program-ROM address lines, the ROM and RAM chip enables, and the nametable address line to the console's internal video RAM. The 8 KiB of pattern memory is a plain RAM with no banking, so this block does not touch it. A separate block handles the cycle-counting interrupt timer.

Program ROM is seen as 16 KiB banks. The lower window ($8000-$BFFF) shows a switchable inner bank. The upper window ($C000-$FFFF) always shows the last inner bank. Both windows sit inside a 256 KiB half that a single outer bit picks. That outer bit is held in four separate one-bit registers, and the video address lines choose which one is in force. If software writes unequal values to them, the outer half changes as the picture is drawn.

The block runs on a fast system clock. A register write takes effect when the bus strobe M2 falls while R/W is low. Every output is registered, so each output follows its inputs by one clock.

Top module: `mapper_prg_ctrl`

## Requirements
- R1: Register decode looks only at CPU address bit 15 (it must be 1) and bits 3..0 (the offset). Offsets 0-3, 8, 9 and 13 are used, and writes to any other offset change nothing.
- R2: A write to offset 0, 1, 2 or 3 loads data bit 0 into the outer-bank register with that index.
- R3: The outer bank bit in force is the register whose index is {ppu_a11, ppu_a10}.
- R4: A write to offset 8 loads data bits 3..0 as the inner bank. While CPU address bit 14 is 0, prg_bank = {outer bit, inner bank}.
- R5: While CPU address bit 14 is 1, prg_bank = {outer bit, 4'b1111}.
- R6: Offset 9 bits 1..0 select the mirroring mode, and ciram_a10 follows it: 0 gives ppu_a10, 1 gives ppu_a11, 2 gives constant 0, 3 gives constant 1.
- R7: Offset 13 bit 5 is the work-RAM enable. ram_ce is 1 only when that bit is set and CPU address bits 15..13 are 3'b011.
- R8: rom_ce equals CPU address bit 15.
- R9: A register loads only on a clock where M2 was high at the previous clock and is low now, with cpu_rw low. Cycles with R/W high, or with M2 held steady, leave every register unchanged.
- R10: A synchronous reset clears all registers and all outputs. After reset, work RAM is disabled, the inner bank is 0, the outer bits are 0 and mirroring is mode 0.
- R11: Each output is registered and shows the value for the inputs and register state present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| m2 | input | 1 | CPU bus phase strobe |
| ppu_a10 | input | 1 | Video address line 10 |
| ppu_a11 | input | 1 | Video address line 11 |
| prg_bank | output | 5 | 16 KiB program-ROM bank number {outer, inner} |
| rom_ce | output | 1 | Program-ROM chip enable |
| ram_ce | output | 1 | Work-RAM chip enable |
| ciram_a10 | output | 1 | Nametable RAM address line 10 |

## Verification
The four outer-bank registers are loaded with the unequal pattern 1,0,1,0, and all four video-address combinations are then swept. This shows whether each register is stored on its own and whether the right one is selected. Inner-bank writes go through aliased addresses, through addresses with bit 15 low, and to unused offsets, which tells true decode apart from a full-address match or a loose one. Each mirroring mode is run against every combination of ppu_a10 and ppu_a11, so a swapped line and a stuck constant look different. Writes with R/W high and with M2 held steady show whether only the falling strobe loads the registers.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int OUTER_REGS = 4;
  localparam int OUTER_SEL_W = $clog2(OUTER_REGS);
  localparam int OFF_W = 4;

  localparam logic [OFF_W-1:0] OFF_INNER  = 4'h8;
  localparam logic [OFF_W-1:0] OFF_MIRROR = 4'h9;
  localparam logic [OFF_W-1:0] OFF_RAMCTL = 4'hD;
  localparam int RAM_EN_BIT = 5;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORIZ  = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;
endpackage

// File: rtl/mapper_bus_strobe.sv
module mapper_bus_strobe (
  input  logic clk,
  input  logic rst,
  input  logic m2,
  input  logic cpu_rw,
  input  logic a15,
  output logic wr_stb
);
  logic m2_q;

  always_ff @(posedge clk) begin
    if (rst) m2_q <= 1'b0;
    else     m2_q <= m2;
  end

  assign wr_stb = m2_q & ~m2 & ~cpu_rw & a15;
endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
  import mapper_pkg::*;
#(
  parameter int INNER_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  logic [OFF_W-1:0]      off,
  input  logic [7:0]            data,
  output logic [OUTER_REGS-1:0] outer_q,
  output logic [INNER_W-1:0]    inner_q,
  output mirror_e               mirror_q,
  output logic                  ram_en_q
);
  logic unused_data_bits;
  assign unused_data_bits = ^data;

  for (genvar i = 0; i < OUTER_REGS; i++) begin : g_outer
    always_ff @(posedge clk) begin
      if (rst) outer_q[i] <= 1'b0;
      else if (wr_stb && off == OFF_W'(i)) outer_q[i] <= data[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inner_q  <= '0;
      mirror_q <= MIR_VERT;
      ram_en_q <= 1'b0;
    end else if (wr_stb) begin
      case (off)
        OFF_INNER:  inner_q  <= data[INNER_W-1:0];
        OFF_MIRROR: mirror_q <= mirror_e'(data[1:0]);
        OFF_RAMCTL: ram_en_q <= data[RAM_EN_BIT];
        default: ;
      endcase
    end
  end

  p_inner_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && off == OFF_INNER) |=> inner_q == $past(data[INNER_W-1:0]));

  p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(inner_q) && $stable(mirror_q) && $stable(ram_en_q) && $stable(outer_q)));
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
  import mapper_pkg::*;
#(
  parameter int INNER_W = 4
) (
  input  logic [OUTER_REGS-1:0]  outer_q,
  input  logic [OUTER_SEL_W-1:0] sel,
  input  logic [INNER_W-1:0]     inner_q,
  input  logic                   a14,
  output logic [INNER_W:0]       bank
);
  logic outer_bit;
  assign outer_bit = outer_q[sel];

  always_comb begin
    if (a14) bank = {outer_bit, {INNER_W{1'b1}}};
    else     bank = {outer_bit, inner_q};
  end
endmodule

// File: rtl/mapper_mirror.sv
module mapper_mirror
  import mapper_pkg::*;
(
  input  mirror_e mode,
  input  logic    ppu_a10,
  input  logic    ppu_a11,
  output logic    ciram_a10
);
  always_comb begin
    unique case (mode)
      MIR_VERT:   ciram_a10 = ppu_a10;
      MIR_HORIZ:  ciram_a10 = ppu_a11;
      MIR_ONE_LO: ciram_a10 = 1'b0;
      MIR_ONE_HI: ciram_a10 = 1'b1;
    endcase
  end
endmodule

// File: rtl/mapper_prg_ctrl.sv
module mapper_prg_ctrl
  import mapper_pkg::*;
#(
  parameter int INNER_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        cpu_addr,
  input  logic [7:0]         cpu_data,
  input  logic               cpu_rw,
  input  logic               m2,
  input  logic               ppu_a10,
  input  logic               ppu_a11,
  output logic [INNER_W:0]   prg_bank,
  output logic               rom_ce,
  output logic               ram_ce,
  output logic               ciram_a10
);
  logic                  wr_stb;
  logic [OUTER_REGS-1:0] outer_q;
  logic [INNER_W-1:0]    inner_q;
  mirror_e               mirror_q;
  logic                  ram_en_q;
  logic [INNER_W:0]      bank_d;
  logic                  cir_d;
  logic                  unused_addr_bits;

  assign unused_addr_bits = ^cpu_addr[12:4];

  mapper_bus_strobe u_strobe (
    .clk(clk), .rst(rst), .m2(m2), .cpu_rw(cpu_rw),
    .a15(cpu_addr[15]), .wr_stb(wr_stb)
  );

  mapper_regs #(.INNER_W(INNER_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .off(cpu_addr[OFF_W-1:0]),
    .data(cpu_data), .outer_q(outer_q), .inner_q(inner_q),
    .mirror_q(mirror_q), .ram_en_q(ram_en_q)
  );

  mapper_prg_map #(.INNER_W(INNER_W)) u_map (
    .outer_q(outer_q), .sel(OUTER_SEL_W'({ppu_a11, ppu_a10})),
    .inner_q(inner_q), .a14(cpu_addr[14]), .bank(bank_d)
  );

  mapper_mirror u_mir (
    .mode(mirror_q), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11), .ciram_a10(cir_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_bank  <= '0;
      rom_ce    <= 1'b0;
      ram_ce    <= 1'b0;
      ciram_a10 <= 1'b0;
    end else begin
      prg_bank  <= bank_d;
      rom_ce    <= cpu_addr[15];
      ram_ce    <= ram_en_q && (cpu_addr[15:13] == 3'b011);
      ciram_a10 <= cir_d;
    end
  end

  p_rom_ce_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rom_ce == $past(cpu_addr[15]));

  p_ram_ce_window_r7: assert property (@(posedge clk) disable iff (rst)
    ram_ce |-> ($past(cpu_addr[15:13]) == 3'b011 && $past(ram_en_q)));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cpu_addr[14])) |-> prg_bank[INNER_W-1:0] == {INNER_W{1'b1}});

  p_onescreen_lo_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mirror_q) == MIR_ONE_LO) |-> !ciram_a10);
endmodule

// File: tb/tb_mapper_prg_ctrl.sv
module tb_mapper_prg_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rw = 1'b1;
  logic        m2 = 1'b0;
  logic        ppu_a10 = 1'b0;
  logic        ppu_a11 = 1'b0;
  logic [4:0]  prg_bank;
  logic        rom_ce, ram_ce, ciram_a10;

  always #2 clk = ~clk;

  mapper_prg_ctrl dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_rw(cpu_rw), .m2(m2), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .prg_bank(prg_bank), .rom_ce(rom_ce), .ram_ce(ram_ce), .ciram_a10(ciram_a10)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R10";

  // reference state
  bit m_outer[4];
  int m_inner, m_mir;
  bit m_ram, m_m2prev;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input logic rw, input logic m);
    int e_bank, e_rom, e_ram, e_cir, osel;
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw = rw; m2 = m;
    if (rst) begin
      e_bank = 0; e_rom = 0; e_ram = 0; e_cir = 0;
      foreach (m_outer[i]) m_outer[i] = 0;
      m_inner = 0; m_mir = 0; m_ram = 0; m_m2prev = 0;
    end else begin
      osel = ppu_a11 * 2 + ppu_a10;
      e_bank = m_outer[osel] * 16 + (a[14] ? 15 : m_inner);
      e_rom = a[15];
      e_ram = (m_ram && a >= 16'h6000 && a < 16'h8000) ? 1 : 0;
      case (m_mir)
        0: e_cir = ppu_a10;
        1: e_cir = ppu_a11;
        2: e_cir = 0;
        default: e_cir = 1;
      endcase
      if (m_m2prev && !m && !rw && a[15]) begin
        case (a[3:0])
          4'h0, 4'h1, 4'h2, 4'h3: m_outer[a[1:0]] = d[0];
          4'h8: m_inner = d[3:0];
          4'h9: m_mir = d[1:0];
          4'hD: m_ram = d[5];
          default: ;
        endcase
      end
      m_m2prev = m;
    end
    @(posedge clk);
    #1;
    chk("prg_bank (R4/R5/R11)", prg_bank, e_bank);
    chk("rom_ce (R8)", rom_ce, e_rom);
    chk("ram_ce (R7)", ram_ce, e_ram);
    chk("ciram_a10 (R6)", ciram_a10, e_cir);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(a, d, 1'b0, 1'b1);
    step(a, d, 1'b0, 1'b0);
    step(a, d, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [15:0] a);
    step(a, 8'h00, 1'b1, 1'b1);
    step(a, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic sweep_ppu(input logic [15:0] a);
    for (int p = 0; p < 4; p++) begin
      ppu_a10 = p[0]; ppu_a11 = p[1];
      rd(a);
    end
    ppu_a10 = 0; ppu_a11 = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    tag = "R10";
    step(16'h8000, 8'hFF, 1'b0, 1'b1);
    step(16'h8008, 8'hFF, 1'b0, 1'b0);
    rst = 1'b0;
    rd(16'h6000);
    rd(16'h8000);
    // R8: ROM enable
    tag = "R8";
    rd(16'h5FFF); rd(16'hFFFF); rd(16'h0000);
    // R4: inner bank, upper data bits ignored
    tag = "R4";
    wr(16'h8008, 8'h05); rd(16'h8123); rd(16'hBFFF);
    wr(16'h8008, 8'hF7); rd(16'h8000);
    // R5: fixed upper window
    tag = "R5";
    rd(16'hC000); rd(16'hFFFF);
    // R2 / R3: unequal outer registers
    tag = "R2";
    wr(16'h8000, 8'h01); wr(16'h8001, 8'hFE); wr(16'h8002, 8'h03); wr(16'h8003, 8'h00);
    tag = "R3";
    sweep_ppu(16'h8000); sweep_ppu(16'hC000);
    tag = "R2";
    wr(16'h8001, 8'h01); wr(16'h8003, 8'h01); sweep_ppu(16'h9000);
    // R1: aliasing and ignored writes
    tag = "R1";
    wr(16'hF0A8, 8'h03); rd(16'h8000);
    wr(16'h7FF8, 8'h09); rd(16'h8000);
    wr(16'h800A, 8'hFF); wr(16'h800B, 8'hFF); wr(16'h800C, 8'hFF);
    wr(16'h800E, 8'hFF); wr(16'h800F, 8'hFF); wr(16'h8004, 8'h00);
    sweep_ppu(16'h8000); rd(16'h6000);
    // R6: mirroring modes against all video line combinations
    tag = "R6";
    for (int md = 0; md < 4; md++) begin
      wr(16'h8009, 8'hFC | 8'(md));
      sweep_ppu(16'h8000);
    end
    // R7: work RAM enable
    tag = "R7";
    wr(16'h800D, 8'h20);
    rd(16'h6000); rd(16'h7FFF); rd(16'h5FFF); rd(16'h8000);
    wr(16'h800D, 8'hDF);
    rd(16'h6000); rd(16'h7ABC);
    // R9: strobe qualification
    tag = "R9";
    step(16'h8008, 8'h0A, 1'b1, 1'b1);
    step(16'h8008, 8'h0A, 1'b1, 1'b0);
    rd(16'h8000);
    step(16'h8008, 8'h0B, 1'b0, 1'b0);
    step(16'h8008, 8'h0B, 1'b0, 1'b0);
    rd(16'h8000);
    step(16'h8008, 8'h0C, 1'b0, 1'b1);
    step(16'h8008, 8'h0C, 1'b0, 1'b1);
    rd(16'h8000);
    wr(16'h800D, 8'h20);
    // R11: back-to-back address changes each cycle
    tag = "R11";
    step(16'h6000, 8'h00, 1'b1, 1'b1);
    step(16'hC000, 8'h00, 1'b1, 1'b0);
    step(16'h8000, 8'h00, 1'b1, 1'b1);
    step(16'h7000, 8'h00, 1'b1, 1'b0);
    // R10: reset again clears everything
    tag = "R10";
    rst = 1'b1;
    step(16'h8000, 8'h00, 1'b1, 1'b0);
    rst = 1'b0;
    rd(16'h6000); sweep_ppu(16'h8000);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule